// File: doc/BRIEF.md
# Successive-Approximation Oscillator Lock Controller

This block is the control sequencer of an all-digital clock generator. It drives a digitally controlled oscillator through a 16-bit control word and brings it to frequency and phase lock in three strictly ordered stages. The first stage is a successive-approximation search on the control word. An external frequency comparator reports whether the oscillator currently runs fast, and the block keeps or drops one trial bit per comparison. The word found is latched into an anchor register, which holds it as the frequency baseline. The second stage is a short, fixed-length phase acquisition. The third is continuous tracking, where the control word is the anchor plus a signed phase correction.

Phase information comes from the oscillator feedback level, which is sampled on the reference clock through two flip-flops in series. The retimed bit reads as "lead" (1) or "lag" (0). Each phase step is scaled by a gain that starts large and halves whenever the lead/lag direction reverses, so the correction settles onto single-LSB dithering. Every pin is a plain level: the control word is valid on every cycle, and no handshake or back-pressure exists at the edge of the block.

Top module: `dco_acq_ctrl`

## Requirements
- R1: While `rst_n` is low, `ctrl_word` is 16'h8000 and `freq_locked` and `locked` are 0.
- R2: The search settles one bit per comparison, from bit 15 down to bit 0. A comparison is made every SETTLE+1 = 2 cycles, and the first is made on the 2nd rising edge after reset release. A `cmp_fast` value of 1 clears the trial bit; a value of 0 keeps it. With an ideal comparator (fast when the word exceeds the target), the result is the target. `freq_locked` rises on the 32nd edge after release.
- R3: When `freq_locked` rises, `anchor_word` holds the word the search found, and `ctrl_word` equals it. The anchor is then held unchanged until reset.
- R4: The lead/lag decision used at a given edge is `dco_fb` as sampled two edges earlier. A value of 1 (lead) subtracts the current gain from the correction, and a value of 0 (lag) adds it.
- R5: Phase acquisition lasts exactly PH_CYC = 8 cycles, well within 10. `locked` rises on edge 40 after release, within 50, and never before `freq_locked`.
- R6: The gain starts at 16. On every update whose direction differs from the previous update, it halves before it is applied, down to a floor of 1. It never grows during acquisition or tracking.
- R7: After frequency lock, `ctrl_word` equals `anchor_word` plus the signed correction, clamped to the range 0 to 16'hFFFF.
- R8: The signed correction saturates at +/-511.
- R9: `freq_locked` and `locked` stay asserted until the next reset.
- R10: `dco_fb` has no effect on the control word during the frequency search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; all state advances on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_fast | input | 1 | Frequency comparator result: 1 when the oscillator runs faster than the target |
| dco_fb | input | 1 | Oscillator feedback level, sampled by the two-flop phase detector |
| ctrl_word | output | 16 | Oscillator control word |
| anchor_word | output | 16 | Baseline word captured at the end of the search |
| freq_locked | output | 1 | Frequency search complete |
| locked | output | 1 | Phase acquisition complete; tracking active |

## Verification
The checker follows the stage ordering and timing on every cycle. It confirms that `locked` implies `freq_locked`, that both flags are sticky, that the phase stage and the total lock time stay within their cycle bounds, and that the anchor is stable after capture and matches the word at the moment of frequency lock. It also confirms that the gain remains a power of two that never rises and that the correction stays inside its saturation range. Only the bench scenarios can show the actual search result for chosen targets, the two-edge latency of the lead/lag decision, the step values after a direction flip, single-LSB dithering, and the clamping of the word at both ends of its range.

// File: rtl/dco_acq_pkg.sv
package dco_acq_pkg;
  typedef enum logic [1:0] {
    ST_FREQ  = 2'd0,
    ST_PHASE = 2'd1,
    ST_TRACK = 2'd2
  } acq_state_e;
endpackage

// File: rtl/dco_sar_search.sv
// Successive-approximation search: one bit per comparison, MSB first.
module dco_sar_search #(
  parameter int CW_W   = 16,
  parameter int SETTLE = 1
) (
  input  logic            clk_ref,
  input  logic            rst_n,
  input  logic            en,
  input  logic            cmp_fast,
  output logic [CW_W-1:0] trial_word,
  output logic [CW_W-1:0] result_word,
  output logic            done
);
  localparam int IDX_W = $clog2(CW_W);
  localparam int CNT_W = (SETTLE > 0) ? $clog2(SETTLE + 1) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE);

  logic [IDX_W-1:0] bit_idx;
  logic [CNT_W-1:0] settle_cnt;
  logic             sample;
  logic [CW_W-1:0]  idx_mask;
  logic [CW_W-1:0]  next_mask;

  always_comb begin
    sample      = (settle_cnt == CNT_LAST);
    idx_mask    = CW_W'(1) << bit_idx;
    next_mask   = (bit_idx == '0) ? '0 : (idx_mask >> 1);
    result_word = cmp_fast ? (trial_word & ~idx_mask) : trial_word;
    done        = en && sample && (bit_idx == '0);
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      trial_word <= CW_W'(1) << (CW_W - 1);
      bit_idx    <= IDX_W'(CW_W - 1);
      settle_cnt <= '0;
    end else if (en) begin
      if (sample) begin
        settle_cnt <= '0;
        trial_word <= result_word | next_mask;
        if (bit_idx != '0) bit_idx <= bit_idx - 1'b1;
      end else begin
        settle_cnt <= settle_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dco_phase_det.sv
// Two series edge-triggered flops: sample then retime the feedback level.
module dco_phase_det (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic dco_fb,
  output logic lead
);
  logic stage1;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= 1'b0;
      lead   <= 1'b0;
    end else begin
      stage1 <= dco_fb;
      lead   <= stage1;
    end
  end
endmodule

// File: rtl/dco_phase_gain.sv
// Signed phase correction with direction-reversal gain halving and saturation.
module dco_phase_gain #(
  parameter int GAIN_INIT = 16,
  parameter int ADJ_W     = 10,
  parameter int GAIN_W    = $clog2(GAIN_INIT + 1)
) (
  input  logic                    clk_ref,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    lead,
  output logic signed [ADJ_W-1:0] adj,
  output logic [GAIN_W-1:0]       gain
);
  localparam int ADJ_MAX = (1 << (ADJ_W - 1)) - 1;
  localparam logic signed [ADJ_W:0] SAT_HI = (ADJ_W + 1)'(ADJ_MAX);
  localparam logic signed [ADJ_W:0] SAT_LO = -SAT_HI;
  localparam logic [GAIN_W-1:0] GAIN_RST = GAIN_W'(GAIN_INIT);

  logic                  have_dir;
  logic                  last_dir;
  logic                  flip;
  logic [GAIN_W-1:0]     gain_eff;
  logic signed [ADJ_W:0] mag;
  logic signed [ADJ_W:0] sum;
  logic signed [ADJ_W:0] sat;

  always_comb begin
    flip     = have_dir && (lead != last_dir);
    gain_eff = gain;
    if (flip) gain_eff = (gain > GAIN_W'(1)) ? (gain >> 1) : GAIN_W'(1);
    mag = $signed({{(ADJ_W + 1 - GAIN_W){1'b0}}, gain_eff});
    sum = $signed({adj[ADJ_W-1], adj}) + (lead ? -mag : mag);
    sat = sum;
    if (sum > SAT_HI) sat = SAT_HI;
    else if (sum < SAT_LO) sat = SAT_LO;
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      adj      <= '0;
      gain     <= GAIN_RST;
      have_dir <= 1'b0;
      last_dir <= 1'b0;
    end else if (!en) begin
      adj      <= '0;
      gain     <= GAIN_RST;
      have_dir <= 1'b0;
    end else begin
      adj      <= sat[ADJ_W-1:0];
      gain     <= gain_eff;
      have_dir <= 1'b1;
      last_dir <= lead;
    end
  end
endmodule

// File: rtl/dco_acq_ctrl.sv
module dco_acq_ctrl
  import dco_acq_pkg::*;
#(
  parameter int CW_W      = 16,
  parameter int SETTLE    = 1,
  parameter int PH_CYC    = 8,
  parameter int GAIN_INIT = 16,
  parameter int ADJ_W     = 10
) (
  input  logic            clk_ref,
  input  logic            rst_n,
  input  logic            cmp_fast,
  input  logic            dco_fb,
  output logic [CW_W-1:0] ctrl_word,
  output logic [CW_W-1:0] anchor_word,
  output logic            freq_locked,
  output logic            locked
);
  localparam int GAIN_W = $clog2(GAIN_INIT + 1);
  localparam int PH_W   = (PH_CYC > 1) ? $clog2(PH_CYC) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PH_CYC - 1);

  acq_state_e                state;
  logic [CW_W-1:0]           trial_word;
  logic [CW_W-1:0]           sar_result;
  logic                      sar_done;
  logic                      pd_lead;
  logic signed [ADJ_W-1:0]   phase_adj;
  logic [GAIN_W-1:0]         phase_gain;
  logic [CW_W-1:0]           anchor_q;
  logic [PH_W-1:0]           ph_cnt;
  logic signed [CW_W+1:0]    wide_sum;
  logic [CW_W-1:0]           track_word;

  dco_sar_search #(.CW_W(CW_W), .SETTLE(SETTLE)) u_sar (
    .clk_ref(clk_ref), .rst_n(rst_n), .en(state == ST_FREQ),
    .cmp_fast(cmp_fast), .trial_word(trial_word),
    .result_word(sar_result), .done(sar_done)
  );

  dco_phase_det u_pd (
    .clk_ref(clk_ref), .rst_n(rst_n), .dco_fb(dco_fb), .lead(pd_lead)
  );

  dco_phase_gain #(.GAIN_INIT(GAIN_INIT), .ADJ_W(ADJ_W), .GAIN_W(GAIN_W)) u_gain (
    .clk_ref(clk_ref), .rst_n(rst_n), .en(state != ST_FREQ),
    .lead(pd_lead), .adj(phase_adj), .gain(phase_gain)
  );

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_FREQ;
      anchor_q <= '0;
      ph_cnt   <= '0;
    end else begin
      case (state)
        ST_FREQ: if (sar_done) begin
          anchor_q <= sar_result;
          ph_cnt   <= '0;
          state    <= ST_PHASE;
        end
        ST_PHASE: begin
          if (ph_cnt == PH_LAST) state <= ST_TRACK;
          else ph_cnt <= ph_cnt + 1'b1;
        end
        ST_TRACK: state <= ST_TRACK;
        default:  state <= ST_FREQ;
      endcase
    end
  end

  always_comb begin
    wide_sum = $signed({2'b00, anchor_q})
             + $signed({{(CW_W + 2 - ADJ_W){phase_adj[ADJ_W-1]}}, phase_adj});
    if (wide_sum[CW_W+1])   track_word = '0;
    else if (wide_sum[CW_W]) track_word = '1;
    else                     track_word = wide_sum[CW_W-1:0];
  end

  assign ctrl_word   = (state == ST_FREQ) ? trial_word : track_word;
  assign anchor_word = anchor_q;
  assign freq_locked = (state != ST_FREQ);
  assign locked      = (state == ST_TRACK);
endmodule

// File: rtl/dco_acq_ctrl_chk.sv
module dco_acq_ctrl_chk #(
  parameter int CW_W     = 16,
  parameter int GAIN_W   = 5,
  parameter int ADJ_W    = 10,
  parameter int LOCK_MAX = 50,
  parameter int PH_MAX   = 10
) (
  input logic                    clk_ref,
  input logic                    rst_n,
  input logic [CW_W-1:0]         ctrl_word,
  input logic [CW_W-1:0]         anchor_word,
  input logic                    freq_locked,
  input logic                    locked,
  input logic [GAIN_W-1:0]       phase_gain,
  input logic signed [ADJ_W-1:0] phase_adj
);
  localparam int ADJ_MAX = (1 << (ADJ_W - 1)) - 1;

  logic [7:0] cyc_cnt;
  logic [7:0] ph_len;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      cyc_cnt <= '0;
      ph_len  <= '0;
    end else begin
      if (cyc_cnt != 8'hFF) cyc_cnt <= cyc_cnt + 1'b1;
      if (freq_locked && !locked && ph_len != 8'hFF) ph_len <= ph_len + 1'b1;
    end
  end

  AST_LOCK_BOUND: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(locked) |-> (int'(cyc_cnt) <= LOCK_MAX)); // R5
  AST_PHASE_LEN: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (freq_locked && !locked) |-> (int'(ph_len) < PH_MAX)); // R5
  AST_LOCK_ORDER: assert property (@(posedge clk_ref) disable iff (!rst_n)
    locked |-> freq_locked); // R5
  AST_LOCK_STICKY: assert property (@(posedge clk_ref) disable iff (!rst_n)
    locked |=> locked); // R9
  AST_FREQ_STICKY: assert property (@(posedge clk_ref) disable iff (!rst_n)
    freq_locked |=> freq_locked); // R9
  AST_ANCHOR_ENTRY: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(freq_locked) |-> (ctrl_word == anchor_word)); // R3
  AST_ANCHOR_HOLD: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (freq_locked && $past(freq_locked)) |-> $stable(anchor_word)); // R3
  AST_GAIN_POW2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $countones(phase_gain) == 1); // R6
  AST_GAIN_NO_RISE: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (freq_locked && $past(freq_locked)) |-> (phase_gain <= $past(phase_gain))); // R6
  AST_ADJ_RANGE: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (int'(phase_adj) <= ADJ_MAX) && (int'(phase_adj) >= -ADJ_MAX)); // R8
endmodule

bind dco_acq_ctrl dco_acq_ctrl_chk #(
  .CW_W(CW_W), .GAIN_W(GAIN_W), .ADJ_W(ADJ_W)
) u_chk (
  .clk_ref(clk_ref), .rst_n(rst_n), .ctrl_word(ctrl_word),
  .anchor_word(anchor_word), .freq_locked(freq_locked), .locked(locked),
  .phase_gain(phase_gain), .phase_adj(phase_adj)
);

// File: tb/dco_acq_ctrl_bench.sv
module dco_acq_ctrl_bench;
  logic        clk_ref = 1'b0;
  logic        rst_n = 1'b0;
  logic        dco_fb = 1'b0;
  logic [15:0] target = 16'h0000;
  logic        cmp_fast;
  logic [15:0] ctrl_word;
  logic [15:0] anchor_word;
  logic        freq_locked;
  logic        locked;
  int          n_chk = 0;
  int          n_fail = 0;
  logic        done = 1'b0;

  always #5 clk_ref = ~clk_ref;

  // Ideal comparator model: oscillator is fast when its word exceeds the target
  assign cmp_fast = (ctrl_word > target);

  dco_acq_ctrl u_dco_acq_ctrl (
    .clk_ref(clk_ref), .rst_n(rst_n), .cmp_fast(cmp_fast), .dco_fb(dco_fb),
    .ctrl_word(ctrl_word), .anchor_word(anchor_word),
    .freq_locked(freq_locked), .locked(locked)
  );

  // {target, fb level, expected word on the lock edge (anchor -/+ 8*16, clamped)}
  localparam logic [32:0] VEC [6] = '{
    {16'h1234, 1'b1, 16'h11B4},
    {16'h0000, 1'b1, 16'h0000},
    {16'hFFFF, 1'b0, 16'hFFFF},
    {16'h8000, 1'b0, 16'h8080},
    {16'h7FFF, 1'b1, 16'h7F7F},
    {16'hA5C3, 1'b0, 16'hA643}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(posedge clk_ref);
    @(negedge clk_ref);
  endtask

  task automatic do_reset();
    @(negedge clk_ref);
    rst_n = 1'b0;
    wait_n(2);
    rst_n = 1'b1;
  endtask

  initial begin
    logic [15:0] w_prev;
    logic [15:0] diff;
    // R1: reset state
    target = 16'h1234;
    dco_fb = 1'b1;
    wait_n(1);
    chk("R1 word", 32'(ctrl_word), 32'h8000);
    chk("R1 flags", {30'd0, freq_locked, locked}, 32'd0);

    // Vector table: search result, anchor, lock timing, lock word
    for (int i = 0; i < 6; i++) begin
      target = VEC[i][32:17];
      dco_fb = VEC[i][16];
      do_reset();
      wait_n(31);
      chk("R2 not yet locked at edge 31", 32'(freq_locked), 32'd0);
      wait_n(1);
      chk("R2 freq lock at edge 32", 32'(freq_locked), 32'd1);
      chk("R3 anchor", 32'(anchor_word), 32'(target));
      chk("R3 word at freq lock", 32'(ctrl_word), 32'(target));
      wait_n(7);
      chk("R5 not locked at edge 39", 32'(locked), 32'd0);
      wait_n(1);
      chk("R5 locked at edge 40", 32'(locked), 32'd1);
      chk("R7 word at lock", 32'(ctrl_word), 32'(VEC[i][15:0]));
    end

    // R10: feedback toggling during the search has no effect on its result
    target = 16'h3C5A;
    dco_fb = 1'b0;
    do_reset();
    for (int k = 0; k < 32; k++) begin
      dco_fb = ~dco_fb;
      wait_n(1);
    end
    chk("R10 freq lock", 32'(freq_locked), 32'd1);
    chk("R10 word at freq lock", 32'(ctrl_word), 32'h3C5A);

    // R4 / R6: two-edge decision latency, halving on direction flip
    target = 16'h8000;
    dco_fb = 1'b1;
    do_reset();
    wait_n(40);
    chk("R4 start word", 32'(ctrl_word), 32'h7F80);
    dco_fb = 1'b0;
    wait_n(1);
    chk("R4 edge1 still lead", 32'(ctrl_word), 32'h7F70);
    wait_n(1);
    chk("R4 edge2 still lead", 32'(ctrl_word), 32'h7F60);
    wait_n(1);
    chk("R6 flip halves gain to 8", 32'(ctrl_word), 32'h7F68);
    wait_n(1);
    chk("R6 gain stays 8", 32'(ctrl_word), 32'h7F70);

    // R6: alternating direction settles to single-LSB dithering
    for (int k = 0; k < 24; k++) begin
      dco_fb = ~dco_fb;
      wait_n(1);
    end
    for (int k = 0; k < 4; k++) begin
      w_prev = ctrl_word;
      dco_fb = ~dco_fb;
      wait_n(1);
      diff = (ctrl_word > w_prev) ? (ctrl_word - w_prev) : (w_prev - ctrl_word);
      chk("R6 gain floor one LSB", 32'(diff), 32'd1);
    end
    chk("R9 lock held", 32'(locked), 32'd1);

    // R8: correction saturates at -511
    target = 16'h8000;
    dco_fb = 1'b1;
    do_reset();
    wait_n(100);
    chk("R8 saturated word", 32'(ctrl_word), 32'h7E01);
    chk("R9 flags held", {30'd0, freq_locked, locked}, 32'd3);

    // R7: clamp at both ends
    target = 16'h0040;
    dco_fb = 1'b1;
    do_reset();
    wait_n(60);
    chk("R7 clamp low", 32'(ctrl_word), 32'h0000);
    target = 16'hFFC0;
    dco_fb = 1'b0;
    do_reset();
    wait_n(60);
    chk("R7 clamp high", 32'(ctrl_word), 32'hFFFF);

    // R1: asynchronous reset mid-track restores reset state
    @(posedge clk_ref);
    #2 rst_n = 1'b0;
    #1;
    chk("R1 async reset word", 32'(ctrl_word), 32'h8000);
    chk("R1 async reset flags", {30'd0, freq_locked, locked}, 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_ref);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule